// File: doc/BRIEF.md
# Reloadable Banked Coefficient Store

This block holds the full tap set of a long FIR equalizer, split across four equal banks so that a multiply-accumulate datapath can fetch four coefficients per clock. A single loader port writes one coefficient per cycle by flat index. The block splits that index into a bank choice and a word position inside the bank, and raises the write enable of exactly one bank. Because it can do this at any time, the filter response can be changed while the filter runs.

On the read side one shared word address, normally driven by the filter's slot counter, addresses every bank in the same cycle. The four results come out together on one wide bus, one clock after the address. This one-cycle latency is fixed so that it lines up with a sample delay line of equal latency. Reset clears the output register but leaves the stored coefficients as they were.

Top module: `coef_bank_store`

## Requirements
- R1: A load with `ld_en`=1 writes `ld_data` into bank `ld_idx[9:8]` at word `ld_idx[7:0]`; a later read of that word in that bank returns the loaded value.
- R2: A load changes only the selected bank; the same word position in the other three banks keeps its value.
- R3: Bits `[16*b+15:16*b]` of `rd_coef` carry bank b's word at the `rd_addr` sampled on the previous rising edge (one-cycle latency), for b = 0..3.
- R4: When a load and a read target the same bank word in the same cycle, the read returns the value held before the load; the new value appears on the next read.
- R5: While `rst_n`=0 (synchronous, active low), `rd_coef` is driven to zero on each edge and loads are ignored; stored coefficients survive reset unchanged.
- R6: With `ld_en`=0, no stored coefficient changes, whatever `ld_idx` and `ld_data` carry.
- R7: Internally at most one bank write enable is active in any cycle, and exactly one whenever `ld_en`=1.
- R8: Loads into some words while other words are being read continuously leave those reads unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for loads and reads |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Load strobe for one coefficient |
| ld_idx | input | 10 | Flat coefficient index: bank in [9:8], word in [7:0] |
| ld_data | input | 16 | Coefficient value to store |
| rd_addr | input | 8 | Word address shared by all banks |
| rd_coef | output | 64 | Four coefficients, bank b in bits [16*b+15:16*b] |

## Verification
On every cycle the assertions check that the load decoder raises at most one bank enable, and exactly one during a load; that reset zeroes the read port; that an idle bank read at an unchanged address keeps its output steady; and that a read which collides with a load returns the earlier contents. Only the bench's scenarios can show that the index split lands each value in the intended bank and word, that reset preserves the coefficients, and that long runs of random loads and reads stay consistent with a flat reference table of 1024 entries.

// File: rtl/coef_pkg.sv
// Package: shared sizing constants for the banked coefficient store.
// Assumes the number of banks and the bank depth are powers of two.
package coef_pkg;
    localparam int unsigned COEF_BANKS_DEF = 4;
    localparam int unsigned COEF_DEPTH_DEF = 256;
    localparam int unsigned COEF_WIDTH_DEF = 16;
endpackage

// File: rtl/coef_load_decode.sv
// Module: coef_load_decode
// Splits a flat coefficient index into a bank select and a bank-local word
// address, and produces one write enable per bank.
// Assumes: upper index bits select the bank, lower bits the word.
module coef_load_decode #(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned BANK_AW   = 8,
    localparam int unsigned SEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int unsigned IDX_W    = SEL_W + BANK_AW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_en,
    input  logic [IDX_W-1:0]     ld_idx,
    output logic [NUM_BANKS-1:0] bank_we,
    output logic [BANK_AW-1:0]   bank_waddr
);

    logic [SEL_W-1:0] bank_sel;

    // Pick out the bank field and the word field of the index.
    always_comb begin
        bank_sel   = ld_idx[IDX_W-1 -: SEL_W];
        bank_waddr = ld_idx[BANK_AW-1:0];
    end

    // Raise the enable of the bank whose number matches the bank field.
    always_comb begin
        bank_we = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (ld_en && (bank_sel == SEL_W'(b))) begin
                bank_we[b] = 1'b1;
            end
        end
    end

    // R7: never two banks written at once.
    p_single_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));

    // R7: a load always reaches exactly one bank.
    p_load_hits_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |-> ($countones(bank_we) == 1));

endmodule

// File: rtl/coef_bank_ram.sv
// Module: coef_bank_ram
// One coefficient bank: simple dual-port memory with a registered read.
// A read and a write to the same word in one cycle return the old word.
// Assumes: reset clears only the read register, never the contents.
module coef_bank_ram #(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned DATA_W = 16,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a coefficient when enabled and out of reset.
    always_ff @(posedge clk) begin
        if (rst_n && we) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Register the addressed word; reset clears the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= mem[rd_addr];
        end
    end

    // R5: reset leaves the read port at zero.
    p_reset_zero_r5: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0));

    // R6: no load and an unchanged address keep the output steady.
    p_idle_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !we && !$past(we) && (rd_addr == $past(rd_addr)))
        |=> $stable(rd_data));

    // R4: a colliding read returns the word held before the load.
    p_collide_old_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (wr_addr == rd_addr)) |=> (rd_data == $past(mem[rd_addr])));

endmodule

// File: rtl/coef_bank_store.sv
// Module: coef_bank_store (top)
// Reloadable coefficient store for a banked FIR datapath. One load port is
// decoded into per-bank enables; all banks read from one shared address and
// return their words together, one clock after the address.
// Assumes: loads and reads share one clock; reads happen every cycle.
module coef_bank_store
    import coef_pkg::*;
#(
    parameter int unsigned NUM_BANKS  = COEF_BANKS_DEF,
    parameter int unsigned BANK_DEPTH = COEF_DEPTH_DEF,
    parameter int unsigned COEF_W     = COEF_WIDTH_DEF,
    localparam int unsigned BANK_AW   = $clog2(BANK_DEPTH),
    localparam int unsigned SEL_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int unsigned IDX_W     = SEL_W + BANK_AW,
    localparam int unsigned BUS_W     = NUM_BANKS * COEF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_en,
    input  logic [IDX_W-1:0]   ld_idx,
    input  logic [COEF_W-1:0]  ld_data,
    input  logic [BANK_AW-1:0] rd_addr,
    output logic [BUS_W-1:0]   rd_coef
);

    logic [NUM_BANKS-1:0] bank_we;
    logic [BANK_AW-1:0]   bank_waddr;

    coef_load_decode #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_AW   (BANK_AW)
    ) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_en      (ld_en),
        .ld_idx     (ld_idx),
        .bank_we    (bank_we),
        .bank_waddr (bank_waddr)
    );

    // One bank per lane of the read bus, all reading the shared address.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        coef_bank_ram #(
            .DEPTH  (BANK_DEPTH),
            .DATA_W (COEF_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (bank_we[b]),
            .wr_addr (bank_waddr),
            .wr_data (ld_data),
            .rd_addr (rd_addr),
            .rd_data (rd_coef[b*COEF_W +: COEF_W])
        );
    end

endmodule

// File: tb/sim_coef_bank_store.sv
// Bench for coef_bank_store: flat reference table of 1024 coefficients,
// seeded random loads and reads plus directed corner cases.
module sim_coef_bank_store;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [9:0]  ld_idx = '0;
    logic [15:0] ld_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [63:0] rd_coef;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [15:0] model [1024];
    logic [63:0] pend = '0;
    bit          pend_v = 1'b0;
    string       ptag = "";
    bit          rst_now = 1'b0;

    always #10 clk = ~clk;

    coef_bank_store u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .ld_idx  (ld_idx),
        .ld_data (ld_data),
        .rd_addr (rd_addr),
        .rd_coef (rd_coef)
    );

    // Expected read bus for address ra from the reference table.
    function automatic logic [63:0] exp_bus(input logic [7:0] ra);
        logic [63:0] v;
        for (int b = 0; b < 4; b++) begin
            v[b*16 +: 16] = model[b*256 + int'(ra)];
        end
        return v;
    endfunction

    // One clock: check the previous cycle's result, then drive new inputs.
    task automatic cyc(input bit ld, input logic [9:0] idx,
                       input logic [15:0] d, input logic [7:0] ra,
                       input string tag);
        @(negedge clk);
        if (pend_v) begin
            checks++;
            if (rd_coef !== pend) begin
                failures++;
                $display("FAIL %s: rd_coef=%h expected=%h", ptag, rd_coef, pend);
            end
        end
        rst_n   = !rst_now;
        ld_en   = ld;
        ld_idx  = idx;
        ld_data = d;
        rd_addr = ra;
        pend    = rst_now ? 64'h0 : exp_bus(ra);
        if (!rst_now && ld) model[idx] = d;
        pend_v  = (tag != "");
        ptag    = tag;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R5: output cleared while reset is held.
        rst_now = 1'b1;
        for (int i = 0; i < 3; i++) cyc(1'b0, 10'd0, 16'd0, 8'd0, "R5");
        rst_now = 1'b0;
        // Fill every coefficient, no checks until all are known.
        for (int i = 0; i < 1024; i++)
            cyc(1'b1, 10'(i), 16'($urandom), 8'd0, "");
        cyc(1'b0, 10'd0, 16'd0, 8'd0, "R3");
        // R3 R8: random loads mixed with continuous reads.
        for (int i = 0; i < 3000; i++)
            cyc(1'($urandom), 10'($urandom), 16'($urandom), 8'($urandom), "R3_R8");
        // R1: index 0x2A5 lands in bank 2 word 0xA5.
        cyc(1'b1, 10'h2A5, 16'h1357, 8'h00, "R1");
        cyc(1'b0, 10'h000, 16'h0000, 8'hA5, "R1");
        cyc(1'b0, 10'h000, 16'h0000, 8'hA5, "R1");
        // R2: same word in each bank with distinct values, then one rewrite.
        cyc(1'b1, 10'h012, 16'hAAAA, 8'h00, "R2");
        cyc(1'b1, 10'h112, 16'hBBBB, 8'h00, "R2");
        cyc(1'b1, 10'h212, 16'hCCCC, 8'h00, "R2");
        cyc(1'b1, 10'h312, 16'hDDDD, 8'h12, "R2");
        cyc(1'b1, 10'h112, 16'h0F0F, 8'h12, "R2");
        cyc(1'b0, 10'h000, 16'h0000, 8'h12, "R2");
        cyc(1'b0, 10'h000, 16'h0000, 8'h12, "R2");
        // R4: colliding load and read return the old value, then the new.
        cyc(1'b1, 10'h140, 16'h5A5A, 8'h40, "R4");
        cyc(1'b1, 10'h340, 16'hC3C3, 8'h40, "R4");
        cyc(1'b0, 10'h000, 16'h0000, 8'h40, "R4");
        cyc(1'b0, 10'h000, 16'h0000, 8'h40, "R4");
        // R6: inactive strobe with live index and data.
        cyc(1'b0, 10'h077, 16'hFFFF, 8'h77, "R6");
        cyc(1'b0, 10'h277, 16'h1111, 8'h77, "R6");
        cyc(1'b0, 10'h000, 16'h0000, 8'h77, "R6");
        cyc(1'b0, 10'h000, 16'h0000, 8'h77, "R6");
        // R5: loads during reset are dropped, contents survive.
        rst_now = 1'b1;
        cyc(1'b1, 10'h033, 16'hBEEF, 8'h33, "R5");
        cyc(1'b1, 10'h233, 16'hFACE, 8'h33, "R5");
        rst_now = 1'b0;
        cyc(1'b0, 10'h000, 16'h0000, 8'h33, "R5");
        cyc(1'b0, 10'h000, 16'h0000, 8'h33, "R5");
        cyc(1'b0, 10'h000, 16'h0000, 8'h00, "R5");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: finished=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule